// File: doc/BRIEF.md
# Serial Audio Link Frame Timer

This block keeps the frame timing for a source-synchronous serial audio link. It runs on the link bit clock (24 MHz in the intended setting). It counts bit clocks into frames of a fixed length, 500 by default, which gives a 48 kHz frame rate. For each frame it produces a start strobe and a sync pulse at the frame's tail. From the same count it derives slot indices for the two data directions. Outbound data moves on both clock edges, so each bit clock carries an even slot (rising edge) and an odd slot (falling edge). Inbound data moves on one edge, so there is one slot per bit clock, lagging the frame count by one cycle to allow for turnaround.

The block also controls link reset. While a reset request is held, the link reset output stays asserted and all timing is quiet. When the request is released, frames start at once and a settling counter runs. When that counter expires, the level of every inbound data line is captured into a codec-presence vector, which then holds until the next link reset.

Top module: `serial_link_frame_timer`

## Requirements
- R1: While `link_rst_req` is high (sampled at a clock edge), from the following cycle `link_rst_n_o` is 0, `bit_slot` and `rx_slot` are 0, `frame_sync` and `frame_start` are 0, and `codec_present` and `present_valid` are 0. Reasserting it in the middle of a frame takes effect in the next cycle.
- R2: While the link runs, `bit_slot` rises by one every bit clock and returns from FRAME_BCLKS-1 (499) to 0.
- R3: `frame_start` is high for exactly the one cycle in which `bit_slot` is 0. The first cycle after link reset is released is such a cycle.
- R4: `frame_sync` is high during the last SYNC_BCLKS (default 4) bit clocks of each frame, which are slots 496 to 499 by default, and low otherwise.
- R5: `tx_slot_even` equals 2·`bit_slot` and `tx_slot_odd` equals 2·`bit_slot`+1, covering outbound slots 0 to 2·FRAME_BCLKS-1 (999).
- R6: With IN_LAG=1 (default), `rx_slot` equals the previous value of `bit_slot`: it is FRAME_BCLKS-1 when `bit_slot` is 0 and `bit_slot`-1 otherwise. With IN_LAG=0 it equals `bit_slot`.
- R7: `present_valid` goes high exactly SETTLE_BCLKS bit clocks after `link_rst_n_o` goes high. In that same cycle `codec_present[i]` takes the level of `sdi_lines[i]` as sampled at that edge.
- R8: Once `present_valid` is high, changes on `sdi_lines` have no effect on `codec_present` until the next link reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| link_rst_req | input | 1 | Request to hold the link in reset |
| sdi_lines | input | SDI_LINES | Inbound data lines, sampled for codec presence |
| link_rst_n_o | output | 1 | Link reset to codecs, active low |
| frame_sync | output | 1 | Sync pulse over the frame tail |
| frame_start | output | 1 | One-cycle strobe at slot 0 |
| bit_slot | output | clog2(FRAME_BCLKS) | Bit clock index within the frame |
| tx_slot_even | output | clog2(2·FRAME_BCLKS) | Outbound slot on the rising edge |
| tx_slot_odd | output | clog2(2·FRAME_BCLKS) | Outbound slot on the falling edge |
| rx_slot | output | clog2(FRAME_BCLKS) | Inbound slot being captured this cycle |
| codec_present | output | SDI_LINES | Presence vector, one bit per inbound line |
| present_valid | output | 1 | Presence vector has been captured |

## Verification
The hardest state to reach is a link reset that arrives partway through a frame after presence has been captured. The design must then leave a running frame with the sync pulse possibly active, and it must clear a vector that is already latched. The bench first walks a full settling interval, with the settle count shortened by a parameter. It then changes the inbound lines to show that the captured vector holds. Only after that does it raise the reset request at an arbitrary slot. A second release with a different line pattern shows that the capture is taken again and not kept from the first run.

// File: rtl/slft_pkg.sv
package slft_pkg;
   typedef enum logic [1:0] {
      PH_HELD   = 2'd0,
      PH_SETTLE = 2'd1,
      PH_LIVE   = 2'd2
   } link_phase_e;
endpackage

// File: rtl/slft_frame_counter.sv
module slft_frame_counter #(
   parameter int FRAME_BCLKS = 500,
   parameter int SYNC_BCLKS  = 4,
   localparam int SW         = $clog2(FRAME_BCLKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          link_rst_req,
   output logic          active,
   output logic [SW-1:0] slot,
   output logic          start,
   output logic          sync
);
   localparam logic [SW-1:0] LAST      = SW'(FRAME_BCLKS - 1);
   localparam logic [SW-1:0] SYNC_FROM = SW'(FRAME_BCLKS - SYNC_BCLKS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         slot   <= '0;
      end else if (link_rst_req) begin
         active <= 1'b0;
         slot   <= '0;
      end else begin
         active <= 1'b1;
         if (!active || slot == LAST) slot <= '0;
         else                         slot <= slot + 1'b1;
      end
   end

   assign start = active && (slot == '0);
   assign sync  = active && (slot >= SYNC_FROM);
endmodule

// File: rtl/slft_slot_map.sv
module slft_slot_map #(
   parameter int FRAME_BCLKS = 500,
   parameter int IN_LAG      = 1,
   localparam int SW         = $clog2(FRAME_BCLKS),
   localparam int TW         = $clog2(2 * FRAME_BCLKS)
) (
   input  logic          active,
   input  logic [SW-1:0] slot,
   output logic [TW-1:0] tx_even,
   output logic [TW-1:0] tx_odd,
   output logic [SW-1:0] rx_slot
);
   localparam logic [SW-1:0] LAST = SW'(FRAME_BCLKS - 1);

   assign tx_even = TW'({slot, 1'b0});
   assign tx_odd  = TW'({slot, 1'b1});

   generate
      if (IN_LAG != 0) begin : g_lagged
         always_comb begin
            if (!active)           rx_slot = '0;
            else if (slot == '0)   rx_slot = LAST;
            else                   rx_slot = slot - 1'b1;
         end
      end else begin : g_aligned
         assign rx_slot = slot;
      end
   endgenerate
endmodule

// File: rtl/slft_presence.sv
module slft_presence
   import slft_pkg::*;
#(
   parameter int SDI_LINES    = 3,
   parameter int SETTLE_BCLKS = 12504,
   localparam int CW          = $clog2(SETTLE_BCLKS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 link_rst_req,
   input  logic [SDI_LINES-1:0] sdi,
   output logic [SDI_LINES-1:0] present,
   output logic                 valid
);
   localparam logic [CW-1:0] DONE_AT = CW'(SETTLE_BCLKS - 1);

   link_phase_e      phase;
   logic [CW-1:0]    wait_cnt;
   logic             grab;

   assign grab  = (phase == PH_SETTLE) && (wait_cnt == DONE_AT) && !link_rst_req;
   assign valid = (phase == PH_LIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_HELD;
         wait_cnt <= '0;
      end else if (link_rst_req) begin
         phase    <= PH_HELD;
         wait_cnt <= '0;
      end else begin
         unique case (phase)
            PH_HELD: begin
               phase    <= PH_SETTLE;
               wait_cnt <= '0;
            end
            PH_SETTLE: begin
               if (wait_cnt == DONE_AT) phase <= PH_LIVE;
               else                     wait_cnt <= wait_cnt + 1'b1;
            end
            PH_LIVE:  phase <= PH_LIVE;
            default:  phase <= PH_HELD;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < SDI_LINES; i++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            present[i] <= 1'b0;
            else if (link_rst_req) present[i] <= 1'b0;
            else if (grab)         present[i] <= sdi[i];
         end
      end
   endgenerate
endmodule

// File: rtl/serial_link_frame_timer.sv
module serial_link_frame_timer #(
   parameter int FRAME_BCLKS  = 500,
   parameter int SYNC_BCLKS   = 4,
   parameter int SETTLE_BCLKS = 12504,
   parameter int SDI_LINES    = 3,
   parameter int IN_LAG       = 1,
   localparam int SW          = $clog2(FRAME_BCLKS),
   localparam int TW          = $clog2(2 * FRAME_BCLKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 link_rst_req,
   input  logic [SDI_LINES-1:0] sdi_lines,
   output logic                 link_rst_n_o,
   output logic                 frame_sync,
   output logic                 frame_start,
   output logic [SW-1:0]        bit_slot,
   output logic [TW-1:0]        tx_slot_even,
   output logic [TW-1:0]        tx_slot_odd,
   output logic [SW-1:0]        rx_slot,
   output logic [SDI_LINES-1:0] codec_present,
   output logic                 present_valid
);
   generate
      if (FRAME_BCLKS < 2) begin : g_bad_frame
         $error("FRAME_BCLKS must be at least 2");
      end
      if (SYNC_BCLKS < 1 || SYNC_BCLKS >= FRAME_BCLKS) begin : g_bad_sync
         $error("SYNC_BCLKS must lie in 1..FRAME_BCLKS-1");
      end
      if (SETTLE_BCLKS < 1) begin : g_bad_settle
         $error("SETTLE_BCLKS must be at least 1");
      end
      if (SDI_LINES < 1 || SDI_LINES > 15) begin : g_bad_lines
         $error("SDI_LINES must lie in 1..15");
      end
      if (IN_LAG != 0 && IN_LAG != 1) begin : g_bad_lag
         $error("IN_LAG must be 0 or 1");
      end
   endgenerate

   logic active;

   slft_frame_counter #(
      .FRAME_BCLKS (FRAME_BCLKS),
      .SYNC_BCLKS  (SYNC_BCLKS)
   ) u_count (
      .clk          (clk),
      .rst_n        (rst_n),
      .link_rst_req (link_rst_req),
      .active       (active),
      .slot         (bit_slot),
      .start        (frame_start),
      .sync         (frame_sync)
   );

   slft_slot_map #(
      .FRAME_BCLKS (FRAME_BCLKS),
      .IN_LAG      (IN_LAG)
   ) u_map (
      .active  (active),
      .slot    (bit_slot),
      .tx_even (tx_slot_even),
      .tx_odd  (tx_slot_odd),
      .rx_slot (rx_slot)
   );

   slft_presence #(
      .SDI_LINES    (SDI_LINES),
      .SETTLE_BCLKS (SETTLE_BCLKS)
   ) u_pres (
      .clk          (clk),
      .rst_n        (rst_n),
      .link_rst_req (link_rst_req),
      .sdi          (sdi_lines),
      .present      (codec_present),
      .valid        (present_valid)
   );

   assign link_rst_n_o = active;
endmodule

// File: rtl/slft_chk.sv
module slft_chk #(
   parameter int FRAME_BCLKS  = 500,
   parameter int SETTLE_BCLKS = 12504,
   parameter int SDI_LINES    = 3,
   parameter int IN_LAG       = 1,
   localparam int SW          = $clog2(FRAME_BCLKS),
   localparam int TW          = $clog2(2 * FRAME_BCLKS),
   localparam int KW          = $clog2(SETTLE_BCLKS + 2)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 link_rst_req,
   input logic                 link_rst_n_o,
   input logic                 frame_sync,
   input logic                 frame_start,
   input logic [SW-1:0]        bit_slot,
   input logic [TW-1:0]        tx_slot_even,
   input logic [TW-1:0]        tx_slot_odd,
   input logic [SW-1:0]        rx_slot,
   input logic [SDI_LINES-1:0] codec_present,
   input logic                 present_valid
);
   localparam logic [KW-1:0] KMAX   = {KW{1'b1}};
   localparam logic [KW-1:0] SETTLE = KW'(SETTLE_BCLKS);

   logic [KW-1:0] since_up;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_up <= '0;
      else if (!link_rst_n_o)     since_up <= '0;
      else if (since_up != KMAX)  since_up <= since_up + 1'b1;
   end

   // R1
   link_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_rst_req |=> (!link_rst_n_o && bit_slot == '0 && !frame_sync &&
                        !frame_start && !present_valid && codec_present == '0));

   // R2
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_rst_n_o && $past(link_rst_n_o)) |->
      (bit_slot == (($past(bit_slot) == SW'(FRAME_BCLKS - 1)) ? '0 : $past(bit_slot) + 1'b1)));

   // R3
   first_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_rst_n_o) |-> frame_start);

   // R3
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   // R4
   sync_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(frame_sync) && link_rst_n_o) |-> frame_start);

   // R5
   tx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_slot_odd == tx_slot_even + 1'b1);

   generate
      if (IN_LAG != 0) begin : g_lag_chk
         // R6
         rx_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (link_rst_n_o && $past(link_rst_n_o)) |-> rx_slot == $past(bit_slot));
      end
   endgenerate

   // R7
   settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(present_valid) |-> since_up == SETTLE);

   // R8
   presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (present_valid && $past(present_valid)) |-> $stable(codec_present));
endmodule

bind serial_link_frame_timer slft_chk #(
   .FRAME_BCLKS  (FRAME_BCLKS),
   .SETTLE_BCLKS (SETTLE_BCLKS),
   .SDI_LINES    (SDI_LINES),
   .IN_LAG       (IN_LAG)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .link_rst_req  (link_rst_req),
   .link_rst_n_o  (link_rst_n_o),
   .frame_sync    (frame_sync),
   .frame_start   (frame_start),
   .bit_slot      (bit_slot),
   .tx_slot_even  (tx_slot_even),
   .tx_slot_odd   (tx_slot_odd),
   .rx_slot       (rx_slot),
   .codec_present (codec_present),
   .present_valid (present_valid)
);

// File: tb/serial_link_frame_timer_tb_top.sv
`timescale 1ns/1ps
module serial_link_frame_timer_tb_top;
   localparam int SETTLE = 1200;
   localparam int NV     = 11;
   // offset after release, bit_slot, frame_start, frame_sync, rx_slot
   localparam int VEC [NV][5] = '{
      '{   0,   0, 1, 0, 499 },
      '{   1,   1, 0, 0,   0 },
      '{ 250, 250, 0, 0, 249 },
      '{ 495, 495, 0, 0, 494 },
      '{ 496, 496, 0, 1, 495 },
      '{ 499, 499, 0, 1, 498 },
      '{ 500,   0, 1, 0, 499 },
      '{ 501,   1, 0, 0,   0 },
      '{ 995, 495, 0, 0, 494 },
      '{ 996, 496, 0, 1, 495 },
      '{1000,   0, 1, 0, 499 }
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       link_rst_req = 1'b1;
   logic [2:0] sdi_lines = 3'b000;
   logic       link_rst_n_o, frame_sync, frame_start, present_valid;
   logic [8:0] bit_slot, rx_slot;
   logic [9:0] tx_slot_even, tx_slot_odd;
   logic [2:0] codec_present;

   int tests = 0;
   int fails = 0;
   int cur   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   serial_link_frame_timer #(.SETTLE_BCLKS(SETTLE)) dut_i (
      .clk(clk), .rst_n(rst_n), .link_rst_req(link_rst_req), .sdi_lines(sdi_lines),
      .link_rst_n_o(link_rst_n_o), .frame_sync(frame_sync), .frame_start(frame_start),
      .bit_slot(bit_slot), .tx_slot_even(tx_slot_even), .tx_slot_odd(tx_slot_odd),
      .rx_slot(rx_slot), .codec_present(codec_present), .present_valid(present_valid));

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
      cur++;
   endtask

   task automatic quiet_check(string tag);
      chk({tag, " R1 link_rst_n_o"}, link_rst_n_o, 0);
      chk({tag, " R1 bit_slot"}, bit_slot, 0);
      chk({tag, " R1 rx_slot"}, rx_slot, 0);
      chk({tag, " R1 frame_sync"}, frame_sync, 0);
      chk({tag, " R1 frame_start"}, frame_start, 0);
      chk({tag, " R1 codec_present"}, codec_present, 0);
      chk({tag, " R1 present_valid"}, present_valid, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #1;
      quiet_check("async reset");
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      quiet_check("held link reset");

      // release; first sample after the next edge is offset 0
      sdi_lines = 3'b101;
      link_rst_req = 1'b0;
      @(posedge clk); #1;
      cur = 0;
      chk("R1 release link_rst_n_o", link_rst_n_o, 1);

      for (int v = 0; v < NV; v++) begin
         while (cur < VEC[v][0]) tick();
         chk("R2 bit_slot", bit_slot, VEC[v][1]);
         chk("R3 frame_start", frame_start, VEC[v][2]);
         chk("R4 frame_sync", frame_sync, VEC[v][3]);
         chk("R6 rx_slot", rx_slot, VEC[v][4]);
         chk("R5 tx_slot_even", tx_slot_even, 2 * VEC[v][1]);
         chk("R5 tx_slot_odd", tx_slot_odd, 2 * VEC[v][1] + 1);
      end

      while (cur < SETTLE - 1) tick();
      chk("R7 valid before settle", present_valid, 0);
      chk("R7 presence before settle", codec_present, 0);
      tick();
      chk("R7 valid at settle", present_valid, 1);
      chk("R7 presence captured", codec_present, 3'b101);

      sdi_lines = 3'b010;
      repeat (7) tick();
      chk("R8 presence ignores lines", codec_present, 3'b101);
      chk("R8 valid holds", present_valid, 1);

      // run into the sync window, then reset mid-frame
      while ((cur % 500) != 497) tick();
      chk("R4 sync before mid-frame reset", frame_sync, 1);
      link_rst_req = 1'b1;
      tick();
      quiet_check("mid-frame");
      repeat (3) tick();
      quiet_check("mid-frame hold");

      // second release with a different line pattern
      link_rst_req = 1'b0;
      @(posedge clk); #1;
      cur = 0;
      chk("R3 first start after release", frame_start, 1);
      chk("R2 slot after release", bit_slot, 0);
      while (cur < SETTLE) tick();
      chk("R7 second capture valid", present_valid, 1);
      chk("R7 second capture value", codec_present, 3'b010);
      chk("R2 slot at settle", bit_slot, SETTLE % 500);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule